// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns CPU read and write requests into cycles on a multiplexed address/data bus. A request carries an address, a byte or word size, a write flag, an instruction-fetch flag and write data; the block places the address on the shared bus, raises an address strobe, then drives a read strobe or write strobes during the data state, and returns read data registered at the end of the transfer. Every bus state lasts `STATE_CLKS` clocks (two by default, one clock per oscillator period).

The width of each cycle is chosen per cycle: when the width-select configuration input is set, the bus-width pin, sampled on the last clock of the address state, picks a 16-bit or an 8-bit cycle; otherwise every cycle is 8-bit. A word on an 8-bit cycle becomes two byte cycles, even byte first. A low ready input at the end of the strobe state adds whole wait states. The address strobe can be a short latch-enable pulse or an active-low address-valid level, and the write strobes can be a single write plus high-byte enable, or separate even-byte and odd-byte write strobes. A hold request releases the bus between transfers.

Top module: `ebus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: read and both write strobes high, hold acknowledge low, bus output enable low, control output enable high, request ready high while hold is low, response valid low, address strobe low in pulse mode.
- R2: A request is accepted on a clock where valid and ready are both high. With ready high the transfer takes an address state, a strobe state and an end state of `STATE_CLKS` clocks each; in pulse mode the address strobe is high only in the first clock of the address state, and response valid pulses for one clock right after the end state.
- R3: When the width-select configuration input is 1, a bus-width pin value of 1 sampled in the address state gives a 16-bit cycle and 0 gives an 8-bit cycle; when the configuration input is 0 every cycle is 8-bit whatever the pin.
- R4: A word transfer on an 8-bit cycle runs as two back-to-back cycles, the first at the even address and the second at the odd address (bit 0 set); the even byte returns in bits 7:0 and the odd byte in bits 15:8, with a single response.
- R5: In address-valid mode the address strobe is low from the first clock of the address state to the last clock of the strobe state and high in the end state and when idle.
- R6: In combined-write mode the write strobe is low during the strobe state of every write, and the high-byte enable is low only when a 16-bit cycle writes the high lane (a word, or a byte at an odd address).
- R7: In split-write mode the low write strobe is low only when the even byte is written and the high write strobe only when the odd byte is written; an 8-bit word write gives one low-strobe cycle then one high-strobe cycle.
- R8: Write data is driven in the strobe state: a 16-bit word as given, a byte replicated on both 8-bit lanes; a byte read at an odd address on a 16-bit cycle takes bits 15:8 of the bus and returns them in bits 7:0 with bits 15:8 zero.
- R9: A low ready input on the last clock of the strobe state adds one further strobe state of `STATE_CLKS` clocks, repeated while ready stays low.
- R10: The fetch indicator is high from the first clock of the address state to the last clock of the end state for instruction-fetch reads and low for data reads and for writes.
- R11: A hold request seen while idle raises hold acknowledge on the next clock; while acknowledged the bus and control output enables are low and request ready is low; dropping hold lowers acknowledge on the next clock.
- R12: A hold request raised during a transfer, including between the two halves of a split word, lets the transfer finish and is acknowledged on the clock after it returns to idle; hold wins over a request arriving in the same clock, and bus request is high while hold is acknowledged and a request is pending.
- R13: The address is driven with the bus output enable high throughout the address state, and the bus is not driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one per oscillator period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bw_pin_en_i | input | 1 | 1: bus-width pin selects width per cycle; 0: always 8-bit |
| cfg_adv_mode_i | input | 1 | 1: address-valid level; 0: latch-enable pulse |
| cfg_split_wr_i | input | 1 | 1: separate even/odd write strobes; 0: write plus high-byte enable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_word_i | input | 1 | 1 word, 0 byte |
| req_inst_i | input | 1 | Read is an instruction fetch |
| req_addr_i | input | BUS_W | Byte address |
| req_wdata_i | input | BUS_W | Write data, byte in bits 7:0 |
| rsp_valid_o | output | 1 | One-clock pulse at transfer completion |
| rsp_rdata_o | output | BUS_W | Read data |
| ad_o | output | BUS_W | Multiplexed address/data out |
| ad_i | input | BUS_W | Multiplexed bus in |
| ad_oe_o | output | 1 | Bus output enable |
| astb_o | output | 1 | Address strobe (pulse or active-low valid) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_wrl_n_o | output | 1 | Write, or even-byte write, active low |
| bhe_wrh_n_o | output | 1 | High-byte enable, or odd-byte write, active low |
| inst_o | output | 1 | Instruction-fetch indicator |
| ctl_oe_o | output | 1 | Control strobe output enable |
| buswidth_i | input | 1 | Bus-width select pin |
| ready_i | input | 1 | Low adds wait states |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Hold acknowledge |
| breq_o | output | 1 | Pending request during hold |

## Verification
The interesting coincidence is a hold request meeting bus traffic: hold may rise in the same clock as a new request, or while a transfer (or the gap between the two halves of a split word) is still running. The bench raises hold together with request valid while idle and expects acknowledge first, bus request high, and the request served only after release, at an exact clock; it also raises hold in the first address state and at the start of the second half, and expects exactly one response followed by acknowledge on the next clock, never a cut transfer.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_HOLD
  } ebus_st_e;
endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int STATE_CLKS = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hold_i,
  input  logic     req_valid_i,
  input  logic     word_i,
  input  logic     cfg_bw_en_i,
  input  logic     buswidth_i,
  input  logic     ready_i,
  output ebus_st_e st_o,
  output logic     ph_first_o,
  output logic     second_o,
  output logic     is16_o,
  output logic     req_ready_o,
  output logic     capture_o,
  output logic     rsp_valid_o
);
  localparam int PH_W = (STATE_CLKS > 1) ? $clog2(STATE_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STATE_CLKS - 1);

  ebus_st_e        st;
  logic [PH_W-1:0] ph;
  logic            last;

  assign last        = (ph == PH_LAST);
  assign st_o        = st;
  assign ph_first_o  = (ph == '0);
  assign req_ready_o = (st == ST_IDLE) && !hold_i;
  assign capture_o   = (st == ST_DATA) && last && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      ph          <= '0;
      second_o    <= 1'b0;
      is16_o      <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          ph       <= '0;
          second_o <= 1'b0;
          if (hold_i) st <= ST_HOLD;
          else if (req_valid_i) st <= ST_ADDR;
        end
        ST_HOLD: if (!hold_i) st <= ST_IDLE;
        ST_ADDR: begin
          if (last) begin
            ph <= '0;
            // width fixed by the first half of a split word
            if (!second_o) is16_o <= cfg_bw_en_i && buswidth_i;
            st <= ST_DATA;
          end else ph <= ph + PH_W'(1);
        end
        ST_DATA: begin
          if (last) begin
            ph <= '0;
            if (ready_i) st <= ST_END;
          end else ph <= ph + PH_W'(1);
        end
        ST_END: begin
          if (last) begin
            ph <= '0;
            if (word_i && !is16_o && !second_o) begin
              second_o <= 1'b1;
              st       <= ST_ADDR;
            end else begin
              st          <= ST_IDLE;
              rsp_valid_o <= 1'b1;
            end
          end else ph <= ph + PH_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_wait_state_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DATA && last && !ready_i) |=> (st == ST_DATA));
  p_hold_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && hold_i) |=> (st == ST_HOLD));
  p_split_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_END && last && word_i && !is16_o && !second_o) |=> (st == ST_ADDR && second_o));
  p_rsp_after_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(st) == ST_END));
endmodule

// File: rtl/ebus_lane.sv
module ebus_lane
  import ebus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ebus_st_e         st_i,
  input  logic             second_i,
  input  logic             is16_i,
  input  logic             write_i,
  input  logic             word_i,
  input  logic [BUS_W-1:0] cur_addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             capture_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] byte_sel;
  logic [BUS_W-1:0]  byte_rep;

  assign byte_sel = (word_i && second_i) ? wdata_i[BUS_W-1:LANE_W] : wdata_i[LANE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_rep
    assign byte_rep[g*LANE_W +: LANE_W] = byte_sel;
  end

  always_comb begin
    ad_o    = cur_addr_i;
    ad_oe_o = 1'b0;
    case (st_i)
      ST_ADDR: ad_oe_o = 1'b1;
      ST_DATA: if (write_i) begin
        ad_oe_o = 1'b1;
        ad_o    = (is16_i && word_i) ? wdata_i : byte_rep;
      end
      default: ad_oe_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (capture_i && !write_i) begin
      if (is16_i && word_i) rdata_o <= ad_i;
      else if (is16_i) rdata_o <= {{LANE_W{1'b0}},
        cur_addr_i[0] ? ad_i[BUS_W-1:LANE_W] : ad_i[LANE_W-1:0]};
      else if (word_i && second_i) rdata_o[BUS_W-1:LANE_W] <= ad_i[LANE_W-1:0];
      else rdata_o <= {{LANE_W{1'b0}}, ad_i[LANE_W-1:0]};
    end
  end
endmodule

// File: rtl/ebus_strobe.sv
module ebus_strobe
  import ebus_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ebus_st_e st_i,
  input  logic     ph_first_i,
  input  logic     write_i,
  input  logic     inst_i,
  input  logic     word_i,
  input  logic     is16_i,
  input  logic     a0_i,
  input  logic     cfg_adv_i,
  input  logic     cfg_split_i,
  input  logic     req_valid_i,
  output logic     astb_o,
  output logic     rd_n_o,
  output logic     wr_wrl_n_o,
  output logic     bhe_wrh_n_o,
  output logic     inst_o,
  output logic     ctl_oe_o,
  output logic     hlda_o,
  output logic     breq_o
);
  logic busy, strobe, wr_act, even_b, odd_b;

  assign busy   = (st_i == ST_ADDR) || (st_i == ST_DATA) || (st_i == ST_END);
  assign strobe = (st_i == ST_DATA);
  assign wr_act = strobe && write_i;
  assign even_b = is16_i ? (word_i || !a0_i) : !a0_i;
  assign odd_b  = is16_i ? (word_i || a0_i) : a0_i;

  assign astb_o = cfg_adv_i ? !((st_i == ST_ADDR) || strobe)
                            : ((st_i == ST_ADDR) && ph_first_i);
  assign rd_n_o      = !(strobe && !write_i);
  assign wr_wrl_n_o  = cfg_split_i ? !(wr_act && even_b) : !wr_act;
  assign bhe_wrh_n_o = cfg_split_i ? !(wr_act && odd_b) : !(wr_act && is16_i && (word_i || a0_i));
  assign inst_o      = busy && !write_i && inst_i;
  assign hlda_o      = (st_i == ST_HOLD);
  assign ctl_oe_o    = !hlda_o;
  assign breq_o      = hlda_o && req_valid_i;

  p_ale_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_adv_i && astb_o) |=> (!astb_o || cfg_adv_i));
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && (!wr_wrl_n_o || !bhe_wrh_n_o)));
endmodule

// File: rtl/ebus_cycle_ctrl.sv
module ebus_cycle_ctrl
  import ebus_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int STATE_CLKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_bw_pin_en_i,
  input  logic             cfg_adv_mode_i,
  input  logic             cfg_split_wr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_word_i,
  input  logic             req_inst_i,
  input  logic [BUS_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  output logic [BUS_W-1:0] rsp_rdata_o,
  output logic [BUS_W-1:0] ad_o,
  input  logic [BUS_W-1:0] ad_i,
  output logic             ad_oe_o,
  output logic             astb_o,
  output logic             rd_n_o,
  output logic             wr_wrl_n_o,
  output logic             bhe_wrh_n_o,
  output logic             inst_o,
  output logic             ctl_oe_o,
  input  logic             buswidth_i,
  input  logic             ready_i,
  input  logic             hold_i,
  output logic             hlda_o,
  output logic             breq_o
);
  ebus_st_e         st;
  logic             ph_first, second, is16, capture, accept;
  logic             q_write, q_word, q_inst;
  logic [BUS_W-1:0] q_addr, q_wdata, cur_addr;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_write <= 1'b0;
      q_word  <= 1'b0;
      q_inst  <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_write <= req_write_i;
      q_word  <= req_word_i;
      q_inst  <= req_inst_i;
      q_addr  <= req_addr_i;
      q_wdata <= req_wdata_i;
    end
  end

  // words are aligned; second half of a split word targets the odd byte
  always_comb begin
    cur_addr = q_addr;
    if (q_word) cur_addr[0] = second;
  end

  ebus_seq #(.STATE_CLKS(STATE_CLKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .req_valid_i(req_valid_i),
    .word_i(q_word), .cfg_bw_en_i(cfg_bw_pin_en_i), .buswidth_i(buswidth_i),
    .ready_i(ready_i), .st_o(st), .ph_first_o(ph_first), .second_o(second),
    .is16_o(is16), .req_ready_o(req_ready_o), .capture_o(capture),
    .rsp_valid_o(rsp_valid_o)
  );

  ebus_lane #(.BUS_W(BUS_W)) u_lane (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .second_i(second), .is16_i(is16),
    .write_i(q_write), .word_i(q_word), .cur_addr_i(cur_addr), .wdata_i(q_wdata),
    .capture_i(capture), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .rdata_o(rsp_rdata_o)
  );

  ebus_strobe u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .ph_first_i(ph_first),
    .write_i(q_write), .inst_i(q_inst), .word_i(q_word), .is16_i(is16),
    .a0_i(cur_addr[0]), .cfg_adv_i(cfg_adv_mode_i), .cfg_split_i(cfg_split_wr_i),
    .req_valid_i(req_valid_i), .astb_o(astb_o), .rd_n_o(rd_n_o),
    .wr_wrl_n_o(wr_wrl_n_o), .bhe_wrh_n_o(bhe_wrh_n_o), .inst_o(inst_o),
    .ctl_oe_o(ctl_oe_o), .hlda_o(hlda_o), .breq_o(breq_o)
  );

  p_hold_float_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !ctl_oe_o));
  p_hold_blocks_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !req_ready_o);
  p_read_no_drive_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
endmodule

// File: tb/ebus_cycle_ctrl_tb_top.sv
module ebus_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bw = 1'b1, cfg_adv = 1'b0, cfg_split = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_inst = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, ad_oe, astb, rd_n, wrl_n, wrh_n, inst, ctl_oe, hlda, breq;
  logic [15:0] rsp_rdata, ad_o, ad_i;
  logic        buswidth = 1'b1, ready = 1'b1, hold = 1'b0;
  logic        bw8 = 1'b0;
  logic [15:0] lat_a = '0;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] byte_at(input logic [15:0] b);
    return b[7:0] + 8'h11 + b[15:8];
  endfunction

  assign ad_i = bw8 ? {8'h00, byte_at(lat_a)}
                    : {byte_at(lat_a | 16'h1), byte_at(lat_a & 16'hFFFE)};

  ebus_cycle_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_bw_pin_en_i(cfg_bw), .cfg_adv_mode_i(cfg_adv),
    .cfg_split_wr_i(cfg_split), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_word_i(req_word), .req_inst_i(req_inst),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe), .astb_o(astb),
    .rd_n_o(rd_n), .wr_wrl_n_o(wrl_n), .bhe_wrh_n_o(wrh_n), .inst_o(inst),
    .ctl_oe_o(ctl_oe), .buswidth_i(buswidth), .ready_i(ready), .hold_i(hold),
    .hlda_o(hlda), .breq_o(breq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // recorder results
  int r_rsp, r_nrsp, r_ahi, r_alo, r_rd, r_rdoe, r_wl, r_wh, r_inst, r_hlda, r_nlat, r_nwd;
  logic [15:0] r_lat[4];
  logic [15:0] r_wd[4];
  logic [15:0] r_rdata;

  task automatic run_xfer(input bit w, input bit wd, input bit ins, input logic [15:0] a,
                          input logic [15:0] d, input int rdy_hi_at, input int hold_at);
    bit prev_a = 0, prev_w = 0, aph, wst;
    r_rsp = 0; r_nrsp = 0; r_ahi = 0; r_alo = 0; r_rd = 0; r_rdoe = 0; r_wl = 0; r_wh = 0;
    r_inst = 0; r_hlda = 0; r_nlat = 0; r_nwd = 0; r_rdata = '0;
    for (int i = 0; i < 4; i++) begin r_lat[i] = '0; r_wd[i] = '0; end
    @(negedge clk);
    req_write = w; req_word = wd; req_inst = ins; req_addr = a; req_wdata = d; req_valid = 1'b1;
    if (rdy_hi_at > 0) ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      if (c == rdy_hi_at) ready = 1'b1;
      if (c == hold_at) hold = 1'b1;
      aph = ad_oe && rd_n && wrl_n && wrh_n && ctl_oe;
      if (aph && !prev_a) begin
        lat_a = ad_o;
        if (r_nlat < 4) r_lat[r_nlat] = ad_o;
        r_nlat++;
      end
      prev_a = aph;
      wst = !wrl_n || !wrh_n;
      if (wst && !prev_w) begin
        if (r_nwd < 4) r_wd[r_nwd] = ad_o;
        r_nwd++;
      end
      prev_w = wst;
      if (astb) r_ahi++; else r_alo++;
      if (!rd_n) r_rd++;
      if (!rd_n && ad_oe) r_rdoe++;
      if (!wrl_n) r_wl++;
      if (!wrh_n) r_wh++;
      if (inst) r_inst++;
      if (hlda && r_hlda == 0) r_hlda = c;
      if (rsp_valid) begin
        if (r_rsp == 0) r_rsp = c;
        r_nrsp++;
        r_rdata = rsp_rdata;
      end
      if (r_rsp != 0 && c >= r_rsp + 3) break;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rd_n && wrl_n && wrh_n, "R1 strobes idle", {rd_n, wrl_n, wrh_n}, 3'b111);
    chk(!hlda && req_ready, "R1 hlda/ready", {hlda, req_ready}, 2'b01);
    chk(!ad_oe && ctl_oe, "R1 oe", {ad_oe, ctl_oe}, 2'b01);
    chk(!rsp_valid && !astb, "R1 rsp/astb", {rsp_valid, astb}, 2'b00);
  endtask

  task automatic t_read16;
    cfg_bw = 1; buswidth = 1; bw8 = 0;
    run_xfer(0, 1, 0, 16'h1234, 0, 0, 0);
    chk(r_rsp == 7, "R2 response clock", r_rsp, 7);
    chk(r_ahi == 1, "R2 ale pulse width", r_ahi, 1);
    chk(r_rd == 2, "R2 read strobe clocks", r_rd, 2);
    chk(r_nrsp == 1, "R2 single response", r_nrsp, 1);
    chk(r_nlat == 1 && r_lat[0] == 16'h1234, "R13 address phase", r_lat[0], 16'h1234);
    chk(r_rdoe == 0, "R13 bus released on read", r_rdoe, 0);
    chk(r_rdata == {byte_at(16'h1235), byte_at(16'h1234)}, "R3 16-bit word read",
        r_rdata, {byte_at(16'h1235), byte_at(16'h1234)});
    chk(r_inst == 0, "R10 data read inst", r_inst, 0);
  endtask

  task automatic t_read8_word;
    cfg_bw = 0; buswidth = 1; bw8 = 1;
    run_xfer(0, 1, 0, 16'h2040, 0, 0, 0);
    chk(r_rsp == 13, "R3 pin ignored, 8-bit split timing", r_rsp, 13);
    chk(r_nlat == 2 && r_lat[0] == 16'h2040 && r_lat[1] == 16'h2041, "R4 address order",
        {r_lat[0], r_lat[1]}, {16'h2040, 16'h2041});
    chk(r_rdata == {byte_at(16'h2041), byte_at(16'h2040)}, "R4 assembled word",
        r_rdata, {byte_at(16'h2041), byte_at(16'h2040)});
    chk(r_nrsp == 1 && r_rd == 4, "R4 one response two strobes", {r_nrsp, r_rd}, {32'd1, 32'd4});
    cfg_bw = 1; buswidth = 0;
    run_xfer(0, 1, 0, 16'h2050, 0, 0, 0);
    chk(r_rsp == 13, "R3 pin low gives 8-bit", r_rsp, 13);
    bw8 = 0; buswidth = 1;
  endtask

  task automatic t_byte_odd16;
    run_xfer(0, 0, 0, 16'h3005, 0, 0, 0);
    chk(r_rdata == {8'h00, byte_at(16'h3005)}, "R8 odd byte from high lane",
        r_rdata, {8'h00, byte_at(16'h3005)});
    chk(r_lat[0] == 16'h3005, "R13 byte address", r_lat[0], 16'h3005);
  endtask

  task automatic t_wait;
    run_xfer(0, 1, 0, 16'h1000, 0, 5, 0);
    chk(r_rsp == 9 && r_rd == 4, "R9 one wait state", r_rsp, 9);
    run_xfer(0, 1, 0, 16'h1000, 0, 7, 0);
    chk(r_rsp == 11 && r_rd == 6, "R9 two wait states", r_rsp, 11);
    chk(r_rdata == {byte_at(16'h1001), byte_at(16'h1000)}, "R9 data after wait",
        r_rdata, {byte_at(16'h1001), byte_at(16'h1000)});
  endtask

  task automatic t_write_comb;
    cfg_split = 0;
    run_xfer(1, 1, 0, 16'h4000, 16'hBEEF, 0, 0);
    chk(r_wl == 2 && r_wh == 2, "R6 word write strobes", {r_wl, r_wh}, {32'd2, 32'd2});
    chk(r_wd[0] == 16'hBEEF, "R8 word write data", r_wd[0], 16'hBEEF);
    run_xfer(1, 0, 0, 16'h4002, 16'h007E, 0, 0);
    chk(r_wl == 2 && r_wh == 0, "R6 even byte no bhe", {r_wl, r_wh}, {32'd2, 32'd0});
    chk(r_wd[0] == 16'h7E7E, "R8 byte replicated", r_wd[0], 16'h7E7E);
    run_xfer(1, 0, 0, 16'h4003, 16'h005A, 0, 0);
    chk(r_wl == 2 && r_wh == 2, "R6 odd byte bhe", {r_wl, r_wh}, {32'd2, 32'd2});
    cfg_bw = 0;
    run_xfer(1, 1, 0, 16'h4010, 16'hCAFE, 0, 0);
    chk(r_wl == 4 && r_wh == 0 && r_rsp == 13, "R6 8-bit word write", {r_wl, r_wh}, {32'd4, 32'd0});
    chk(r_wd[0][7:0] == 8'hFE && r_wd[1][7:0] == 8'hCA, "R4 write byte order",
        {r_wd[0][7:0], r_wd[1][7:0]}, 16'hFECA);
    cfg_bw = 1;
  endtask

  task automatic t_write_split;
    cfg_split = 1;
    run_xfer(1, 1, 0, 16'h5000, 16'h1357, 0, 0);
    chk(r_wl == 2 && r_wh == 2, "R7 word both strobes", {r_wl, r_wh}, {32'd2, 32'd2});
    run_xfer(1, 0, 0, 16'h5002, 16'h0011, 0, 0);
    chk(r_wl == 2 && r_wh == 0, "R7 even byte low strobe", {r_wl, r_wh}, {32'd2, 32'd0});
    run_xfer(1, 0, 0, 16'h5003, 16'h0022, 0, 0);
    chk(r_wl == 0 && r_wh == 2, "R7 odd byte high strobe", {r_wl, r_wh}, {32'd0, 32'd2});
    cfg_bw = 0;
    run_xfer(1, 1, 0, 16'h5010, 16'hA1B2, 0, 0);
    chk(r_wl == 2 && r_wh == 2 && r_nwd == 2, "R7 8-bit word halves", {r_wl, r_wh}, {32'd2, 32'd2});
    cfg_bw = 1; cfg_split = 0;
  endtask

  task automatic t_adv;
    cfg_adv = 1;
    run_xfer(0, 1, 0, 16'h6000, 0, 0, 0);
    chk(r_alo == 4, "R5 valid low clocks", r_alo, 4);
    @(negedge clk);
    chk(astb == 1'b1, "R5 idle high", astb, 1);
    cfg_adv = 0;
    @(negedge clk);
  endtask

  task automatic t_inst;
    run_xfer(0, 1, 1, 16'h7000, 0, 0, 0);
    chk(r_inst == 6, "R10 fetch indicator clocks", r_inst, 6);
    run_xfer(1, 1, 1, 16'h7002, 16'h0, 0, 0);
    chk(r_inst == 0, "R10 low on write", r_inst, 0);
    cfg_bw = 0; bw8 = 1;
    run_xfer(0, 1, 1, 16'h7010, 0, 0, 0);
    chk(r_inst == 12, "R10 split fetch", r_inst, 12);
    cfg_bw = 1; bw8 = 0;
  endtask

  task automatic t_hold_idle;
    @(negedge clk); hold = 1;
    @(negedge clk);
    chk(hlda && !ad_oe && !ctl_oe && !req_ready, "R11 hold grant", {hlda, ad_oe, ctl_oe, req_ready}, 4'b1000);
    req_valid = 1; #1;
    chk(breq == 1'b1, "R12 bus request pending", breq, 1);
    req_valid = 0; hold = 0;
    @(negedge clk);
    chk(!hlda && req_ready && ctl_oe, "R11 release", {hlda, req_ready, ctl_oe}, 3'b011);
  endtask

  task automatic t_hold_busy;
    run_xfer(0, 1, 0, 16'h1100, 0, 0, 1);
    chk(r_rsp == 7 && r_hlda == 8, "R12 hold after 16-bit cycle", r_hlda, 8);
    @(negedge clk); hold = 0; @(negedge clk);
    cfg_bw = 0; bw8 = 1;
    run_xfer(0, 1, 0, 16'h1200, 0, 0, 7);
    chk(r_nrsp == 1 && r_rsp == 13 && r_nlat == 2, "R12 split not cut", r_rsp, 13);
    chk(r_hlda == 14, "R12 hold after split", r_hlda, 14);
    @(negedge clk); hold = 0; @(negedge clk);
    cfg_bw = 1; bw8 = 0;
  endtask

  task automatic t_hold_vs_req;
    int rk = 0;
    @(negedge clk);
    req_write = 0; req_word = 1; req_inst = 0; req_addr = 16'h1300;
    hold = 1; req_valid = 1;
    @(negedge clk);
    chk(hlda && breq && !req_ready, "R12 hold wins same clock", {hlda, breq, req_ready}, 3'b110);
    hold = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 1) chk(req_ready == 1'b1, "R12 ready after release", req_ready, 1);
      if (k == 2) req_valid = 0;
      if (rsp_valid && rk == 0) rk = k;
    end
    chk(rk == 8, "R12 pending request served", rk, 8);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read16();
    t_read8_word();
    t_byte_odd16();
    t_wait();
    t_write_comb();
    t_write_split();
    t_adv();
    t_inst();
    t_hold_idle();
    t_hold_busy();
    t_hold_vs_req();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule